// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a two-address configuration window for a legacy I/O controller. A byte-wide bus chooses one of two addresses with a single select line. One address holds a register pointer. The other address reads or writes the byte that the pointer selects in a 256-entry configuration array. Each index follows its own write rule. Some entries are locked. Two entries take only one fixed byte value. The remaining entries in the upper range take any byte.

A separate enable input comes from a control bit in a bridge. It decides whether the port responds at all. While the port is disabled, nothing inside changes, reads return all ones and the decode-hit output stays low. Reset loads a small set of fixed defaults and clears everything else.

Top module: `cfg_index_port`

## Requirements
- R1: A write with `io_sel`=0 loads `wr_data` into the pointer. A read with `io_sel`=0 returns the current pointer value.
- R2: A read with `io_sel`=1 returns the entry the pointer selects, whether or not that entry is writable. The result appears on `rd_data` one clock after the cycle in which `rd_stb` is sampled, and it holds until the next read.
- R3: Data writes are discarded at indices 0x00 to 0xDF, 0xE4, 0xE5, 0xE9 to 0xED, 0xF3, 0xF5, 0xF7, 0xF9 to 0xFB, and 0xFD to 0xFF.
- R4: Index 0xE7 stores a data write only when the byte is 0xFE. Any other byte leaves the entry unchanged.
- R5: Index 0xE8 stores a data write only when the byte is 0xBE. Any other byte leaves the entry unchanged.
- R6: Indices 0xE0 to 0xE3, 0xE6, 0xEE to 0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any data byte written to them.
- R7: After reset, the following entries hold these values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. All other entries are 0x00 and the pointer is 0x00.
- R8: While `port_en` is low, the port behaves as follows:
  - A read returns 0xFF.
  - A write changes neither the pointer nor the array.
  - `hit` stays low.
- R9: A read at either address leaves the pointer unchanged.
- R10: `hit` is high in any cycle where `port_en` is high and `rd_stb` or `wr_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Decode enable, driven by the bridge control bit |
| io_sel | input | 1 | 0 selects the pointer address, 1 selects the data address |
| wr_stb | input | 1 | Byte write strobe |
| rd_stb | input | 1 | Byte read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| hit | output | 1 | The port decoded the current access |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, which gives the full 256-entry array, and 0xFF as the byte returned while the port is disabled. With these defaults every write-rule class can be reached through the port. This covers the locked lower range, the scattered locked indices in the upper range, the two single-value entries with both their accepted and their rejected bytes, and the freely writable entries. The bench also checks that a disabled port preserves both the pointer and the array content by reading them back after the port is enabled again.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int          IDX_W       = 8,
  parameter logic [7:0]  IDLE_RDATA  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic       io_sel,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       hit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] ptr_q;
  logic [7:0]       cfg_q [DEPTH];
  logic [7:0]       rd_q;

  function automatic logic [7:0] init_val(input logic [7:0] i);
    case (i)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic may_store(input logic [7:0] i, input logic [7:0] d);
    if (i < 8'hE0) return 1'b0;
    case (i)
      8'hE4, 8'hE5,
      8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
      8'hF3, 8'hF5, 8'hF7,
      8'hF9, 8'hFA, 8'hFB,
      8'hFD, 8'hFE, 8'hFF: return 1'b0;
      8'hE7:               return d == 8'hFE;
      8'hE8:               return d == 8'hBE;
      default:             return 1'b1;
    endcase
  endfunction

  wire ptr_wr  = port_en & wr_stb & ~io_sel;
  wire data_wr = port_en & wr_stb & io_sel & may_store(8'(ptr_q), wr_data);

  assign hit     = port_en & (wr_stb | rd_stb);
  assign rd_data = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) cfg_q[i] <= init_val(8'(i));
    end else begin
      if (ptr_wr)  ptr_q <= IDX_W'(wr_data);
      if (data_wr) cfg_q[ptr_q] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_q <= '0;
    else if (rd_stb)
      rd_q <= !port_en ? IDLE_RDATA : (io_sel ? cfg_q[ptr_q] : 8'(ptr_q));
  end

  // R2
  data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && port_en && io_sel) |=> rd_data == $past(cfg_q[ptr_q]));

  // R3
  locked_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && io_sel && ptr_q < IDX_W'(8'hE0)) |=> $stable(cfg_q[ptr_q]));

  // R4
  e7_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[8'hE7] == 8'hFE);

  // R5
  e8_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[8'hE8] == 8'hBE);

  // R8
  disabled_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !port_en) |=> rd_data == IDLE_RDATA);

  // R8
  disabled_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en) |=> $stable(ptr_q));

  // R9
  read_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb) |=> $stable(ptr_q));
endmodule

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0;
  logic       io_sel = 1'b0;
  logic       wr_stb = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_index_port u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .io_sel(io_sel),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data),
    .rd_data(rd_data), .hit(hit)
  );

  // {index, written byte, expected readback}
  localparam logic [23:0] VEC [26] = '{
    {8'hE7, 8'h00, 8'hFE}, {8'hE7, 8'hFE, 8'hFE}, {8'hE7, 8'hFF, 8'hFE},
    {8'hE8, 8'h12, 8'hBE}, {8'hE8, 8'hBE, 8'hBE},
    {8'h00, 8'h55, 8'h00}, {8'hDF, 8'h11, 8'h00}, {8'h80, 8'hAA, 8'h00},
    {8'hE4, 8'h21, 8'h00}, {8'hE5, 8'h22, 8'h00}, {8'hE9, 8'h23, 8'h00},
    {8'hED, 8'h24, 8'h00}, {8'hF3, 8'h25, 8'h00}, {8'hF7, 8'h26, 8'h00},
    {8'hFA, 8'h27, 8'h00}, {8'hFF, 8'h28, 8'h00},
    {8'hE0, 8'hA5, 8'hA5}, {8'hE1, 8'h77, 8'h77}, {8'hEE, 8'h12, 8'h12},
    {8'hF2, 8'h34, 8'h34}, {8'hF4, 8'h56, 8'h56}, {8'hF6, 8'h78, 8'h78},
    {8'hF8, 8'h9A, 8'h9A}, {8'hFC, 8'hBC, 8'hBC}, {8'hE6, 8'h01, 8'h01},
    {8'hE3, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    io_sel = sel; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    io_sel = sel; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic rd_at(input logic [7:0] idx, output logic [7:0] v);
    do_wr(1'b0, idx);
    do_rd(1'b1, v);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    port_en = 1'b1;

    do_rd(1'b0, v);               check("R7 pointer", v, 8'h00);
    rd_at(8'hE0, v);              check("R7 E0", v, 8'h3C);
    rd_at(8'hE2, v);              check("R7 E2", v, 8'h03);
    rd_at(8'hE3, v);              check("R7 E3", v, 8'hFC);
    rd_at(8'hE6, v);              check("R7 E6", v, 8'hDE);
    rd_at(8'hE7, v);              check("R7 E7", v, 8'hFE);
    rd_at(8'hE8, v);              check("R7 E8", v, 8'hBE);
    rd_at(8'hE1, v);              check("R7 E1", v, 8'h00);
    do_rd(1'b0, v);               check("R1 pointer readback", v, 8'hE1);

    for (int k = 0; k < 26; k++) begin
      do_wr(1'b0, VEC[k][23:16]);
      do_wr(1'b1, VEC[k][15:8]);
      do_rd(1'b1, v);
      check("R2/R3/R4/R5/R6 table", v, VEC[k][7:0]);
    end

    do_rd(1'b1, v);
    do_rd(1'b1, v);
    do_rd(1'b0, v);               check("R9 pointer after reads", v, 8'hE3);

    @(negedge clk);
    io_sel = 1'b1; rd_stb = 1'b1;
    #1 check("R10 hit enabled", 8'(hit), 8'h01);
    @(negedge clk);
    rd_stb = 1'b0;

    port_en = 1'b0;
    @(negedge clk);
    wr_stb = 1'b1; io_sel = 1'b0; wr_data = 8'hE0;
    #1 check("R8 hit low", 8'(hit), 8'h00);
    @(negedge clk);
    wr_stb = 1'b0;
    do_wr(1'b1, 8'h99);
    do_rd(1'b1, v);               check("R8 disabled read", v, 8'hFF);
    do_rd(1'b0, v);               check("R8 disabled pointer read", v, 8'hFF);
    port_en = 1'b1;
    do_rd(1'b0, v);               check("R8 pointer kept", v, 8'hE3);
    do_rd(1'b1, v);               check("R8 entry E3 kept", v, 8'h00);
    rd_at(8'hE0, v);              check("R8 entry E0 kept", v, 8'hA5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule